// File: doc/BRIEF.md
# Serial NOR Flash Command Front End

This block is the target side of a serial flash memory's command interface, modelled at the behavioural level over a small internal byte array. A host selects the device with an active-low chip select and clocks in an opcode, then an address and data where the opcode needs them. The block samples the serial clock, chip select and hold with its own system clock. It finds rising and falling serial clock edges from those samples, so the whole design is one clock domain.

The block decodes each instruction. It keeps a write-enable latch and a write-in-progress flag, and it answers the identification, status and read instructions. Reads come out on one pin, or on two pins for the dual-output read. Instructions that change state run only when chip select rises on an allowed bit count and the write-enable latch is set. A modifying instruction starts a stubbed busy timer. While the timer runs, only the status read is served. A deep power-down state silences everything except the release instruction. The hold input freezes a transfer in place without ending it.

Top module: `flash_cmd_front`

## Requirements
- R1: Input bits are taken most significant bit first on rising serial clock edges while chip select is low. Output bits change only after falling serial clock edges, and the outputs are not driven after reset or while deselected.
- R2: Opcode 9Fh returns the bytes 20h, 71h and 17h, in that order.
- R3: Opcode 05h returns the status byte repeatedly. Bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7:2 hold the value last written with opcode 01h. Status can be read while a busy cycle is running.
- R4: Opcode 06h sets the write-enable latch and 04h clears it. Each takes effect only when chip select rises after exactly 8 clocks.
- R5: Page program (02h), block erase (20h), full erase (C7h) and status write (01h) have no effect, and start no busy cycle, unless the write-enable latch is set.
- R6: A modifying instruction runs only if chip select rises on a byte boundary with the right length. Status write and full erase need exactly 16 and 8 clocks. Block erase needs exactly 32 clocks. Page program needs 40 clocks or more. Otherwise the instruction is discarded and the latch is unchanged.
- R7: An executed modifying instruction holds write-in-progress at 1 for BUSY_CYCLES system clocks and then clears the write-enable latch. During that time every instruction except 05h is ignored.
- R8: Read (03h) takes a 3-byte address and fast read (0Bh) takes a 3-byte address plus one dummy byte. Both then return array bytes from that address upward, wrapping at the top of the array.
- R9: Dual read (3Bh) has the same framing as 0Bh. It returns two bits per clock, with DQ1 carrying the higher bit of each pair and DQ0 the lower.
- R10: Page program ANDs its data into the array, wrapping within a 2^PW-byte page. Opcode 20h sets to FFh the 2^EW-byte block that holds the address. Opcode C7h sets the whole array to FFh.
- R11: Opcode B9h (8 clocks) enters deep power-down. There every instruction is ignored and no output is driven, except AB h, which releases the block after 8 clocks.
- R12: While hold is low, serial clock edges are ignored and the outputs are released. The transfer then continues from the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock (mode 0) |
| hold_n | input | 1 | Hold, active low |
| dq0_i | input | 1 | Serial data in on DQ0 |
| dq0_o | output | 1 | DQ0 output data (dual read) |
| dq0_oe | output | 1 | DQ0 output enable |
| dq1_o | output | 1 | DQ1 output data |
| dq1_oe | output | 1 | DQ1 output enable |

## Verification
Several properties are checked on every cycle. The bit counter stays frozen while hold is low. The array changes only on an execute strobe. Write-in-progress rises only when the latch was set, and its fall leaves the latch clear. The write-enable latch rises only just after a deselect. DQ1 changes only following a falling serial clock edge, and nothing is driven during deep power-down. The bench scenarios are the only evidence for the returned byte values. Those scenarios cover identification, status, the read variants with their wrap, the program and erase contents, discarding on a bad bit count, ignoring instructions while busy or asleep, and resuming cleanly after hold.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDID  = 8'h9F;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_DUAL  = 8'h3B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_BLKER = 8'h20;
  localparam logic [7:0] OP_ALLER = 8'hC7;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  localparam logic [7:0] ID_MFR  = 8'h20;
  localparam logic [7:0] ID_TYPE = 8'h71;
  localparam logic [7:0] ID_CAP  = 8'h17;

  typedef enum logic [1:0] {OUT_NONE, OUT_SINGLE, OUT_DUAL} out_mode_e;
  typedef enum logic [1:0] {SRC_MEM, SRC_ID, SRC_STAT} out_src_e;
endpackage

// File: rtl/flash_fe_shift.sv
module flash_fe_shift #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             hold_n,
  input  logic             din,
  output logic             fall,
  output logic             byte_stb,
  output logic [7:0]       byte_val,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             desel
);
  logic             sclk_q, cs_q;
  logic [6:0]       sr, sr_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic             live, rise;

  assign live     = ~cs_n & hold_n;
  assign rise     = live & sclk & ~sclk_q;
  assign fall     = live & ~sclk & sclk_q;
  assign byte_stb = rise & (bit_cnt[2:0] == 3'd7);
  assign byte_val = {sr, din};
  assign desel    = cs_n & ~cs_q;

  always_comb begin
    sr_nx  = sr;
    cnt_nx = bit_cnt;
    if (rise) sr_nx = {sr[5:0], din};
    if (cs_n) cnt_nx = '0;
    else if (rise && !(&bit_cnt)) cnt_nx = bit_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      sr      <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_q  <= sclk;
      cs_q    <= cs_n;
      sr      <= sr_nx;
      bit_cnt <= cnt_nx;
    end
  end

  // R12: a held transfer keeps its bit position
  assert_hold_freezes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n) |=> $stable(bit_cnt));
endmodule

// File: rtl/flash_fe_busy.sv
module flash_fe_busy #(
  parameter int BUSY_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic wip,
  output logic done
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [BW-1:0] LOAD = BW'(BUSY_CYCLES);

  logic [BW-1:0] cnt, cnt_nx;

  assign wip  = (cnt != '0);
  assign done = (cnt == BW'(1));

  always_comb begin
    cnt_nx = cnt;
    if (start && !wip) cnt_nx = LOAD;
    else if (wip)      cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  // R7: an accepted execute strobe always enters the busy state
  assert_start_sets_wip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> wip);
endmodule

// File: rtl/flash_fe_array.sv
module flash_fe_array #(
  parameter int AW = 6,
  parameter int PW = 3,
  parameter int EW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog,
  input  logic [AW-PW-1:0]      prog_page,
  input  logic [(1<<PW)-1:0][7:0] prog_data,
  input  logic [(1<<PW)-1:0]    prog_mask,
  input  logic                  erase_blk,
  input  logic [AW-EW-1:0]      erase_base,
  input  logic                  erase_all,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][7:0] mem, mem_nx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [AW-1:0] IDX = AW'(g);
    assign mem_nx[g] =
      (erase_all || (erase_blk && erase_base == IDX[AW-1:EW])) ? 8'hFF :
      (prog && prog_mask[IDX[PW-1:0]] && prog_page == IDX[AW-1:PW]) ?
        (mem[g] & prog_data[IDX[PW-1:0]]) : mem[g];
  end

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem <= '1;
    else        mem <= mem_nx;
  end

  // R5: cell contents move only on an execute strobe
  assert_array_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog || erase_blk || erase_all) |=> $stable(mem));
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_fe_pkg::*;
#(
  parameter int AW          = 6,
  parameter int PW          = 3,
  parameter int EW          = 4,
  parameter int BUSY_CYCLES = 400,
  parameter int CNT_W       = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic hold_n,
  input  logic dq0_i,
  output logic dq0_o,
  output logic dq0_oe,
  output logic dq1_o,
  output logic dq1_oe
);
  localparam int PAGE = 1 << PW;
  localparam logic [CNT_W-1:0] N8  = CNT_W'(8);
  localparam logic [CNT_W-1:0] N16 = CNT_W'(16);
  localparam logic [CNT_W-1:0] N32 = CNT_W'(32);
  localparam logic [CNT_W-1:0] N40 = CNT_W'(40);
  localparam logic [CNT_W-4:0] B1  = (CNT_W-3)'(1);
  localparam logic [CNT_W-4:0] B3  = (CNT_W-3)'(3);
  localparam logic [CNT_W-4:0] B4  = (CNT_W-3)'(4);

  logic             fall, byte_stb, desel;
  logic [7:0]       byte_val;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-4:0] byte_idx;

  flash_fe_shift #(.CNT_W(CNT_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .hold_n(hold_n),
    .din(dq0_i), .fall(fall), .byte_stb(byte_stb), .byte_val(byte_val),
    .bit_cnt(bit_cnt), .desel(desel));

  assign byte_idx = bit_cnt[CNT_W-1:3];

  // command state
  logic [7:0]            op, op_nx;
  logic [AW-1:0]         addr, addr_nx, addr_full, rd_ptr, rd_ptr_nx;
  logic [5:0]            wr_hi, wr_hi_nx, sr_hi, sr_hi_nx;
  logic                  wel, wel_nx, dpd, dpd_nx, drive, drive_nx;
  logic [7:0]            out_sr, out_sr_nx;
  logic [PAGE-1:0][7:0]  pbuf, pbuf_nx;
  logic [PAGE-1:0]       pmask, pmask_nx;
  logic [PW-1:0]         wr_off, wr_off_nx;
  logic [AW-PW-1:0]      ppage, ppage_nx;

  logic wip, done, start;
  logic [7:0] rd_data, src_byte;

  // output decode
  out_mode_e        omode;
  out_src_e         osrc;
  logic [CNT_W-1:0] hdr, rel;
  logic             has_addr, allowed, in_data, load;

  always_comb begin
    omode    = OUT_NONE;
    osrc     = SRC_MEM;
    hdr      = N8;
    has_addr = 1'b0;
    case (op)
      OP_READ:  begin omode = OUT_SINGLE; hdr = N32; has_addr = 1'b1; end
      OP_FAST:  begin omode = OUT_SINGLE; hdr = N40; has_addr = 1'b1; end
      OP_DUAL:  begin omode = OUT_DUAL;   hdr = N40; has_addr = 1'b1; end
      OP_RDSR:  begin omode = OUT_SINGLE; osrc = SRC_STAT; end
      OP_RDID:  begin omode = OUT_SINGLE; osrc = SRC_ID; end
      OP_PROG, OP_BLKER: has_addr = 1'b1;
      default: ;
    endcase
  end

  assign allowed = ~dpd & (~wip | (op == OP_RDSR)) & (bit_cnt >= N8) & (omode != OUT_NONE);
  assign in_data = allowed & (bit_cnt >= hdr);
  assign rel     = bit_cnt - hdr;
  assign load    = (omode == OUT_DUAL) ? (rel[1:0] == 2'd0) : (rel[2:0] == 3'd0);

  always_comb begin
    case (osrc)
      SRC_STAT: src_byte = {sr_hi, wel, wip};
      SRC_ID: begin
        case (rd_ptr)
          AW'(0):  src_byte = ID_MFR;
          AW'(1):  src_byte = ID_TYPE;
          AW'(2):  src_byte = ID_CAP;
          default: src_byte = 8'h00;
        endcase
      end
      default: src_byte = rd_data;
    endcase
  end

  // execute on deselect
  logic aligned, ex_ok, mod_ok, wren_x, wrdi_x, prog_x, blk_x, all_x, wrsr_x, sleep_x, wake_x;

  assign aligned = desel & (bit_cnt[2:0] == 3'd0);
  assign ex_ok   = aligned & ~wip & ~dpd;
  assign mod_ok  = ex_ok & wel;
  assign wren_x  = ex_ok  & (op == OP_WREN)  & (bit_cnt == N8);
  assign wrdi_x  = ex_ok  & (op == OP_WRDI)  & (bit_cnt == N8);
  assign prog_x  = mod_ok & (op == OP_PROG)  & (bit_cnt >= N40);
  assign blk_x   = mod_ok & (op == OP_BLKER) & (bit_cnt == N32);
  assign all_x   = mod_ok & (op == OP_ALLER) & (bit_cnt == N8);
  assign wrsr_x  = mod_ok & (op == OP_WRSR)  & (bit_cnt == N16);
  assign sleep_x = ex_ok  & (op == OP_SLEEP) & (bit_cnt == N8);
  assign wake_x  = aligned & dpd & (op == OP_WAKE) & (bit_cnt == N8);
  assign start   = prog_x | blk_x | all_x | wrsr_x;

  assign addr_full = AW'({addr, byte_val});

  always_comb begin
    op_nx     = op;
    addr_nx   = addr;
    rd_ptr_nx = rd_ptr;
    wr_hi_nx  = wr_hi;
    sr_hi_nx  = sr_hi;
    wel_nx    = wel;
    dpd_nx    = dpd;
    drive_nx  = drive;
    out_sr_nx = out_sr;
    pbuf_nx   = pbuf;
    pmask_nx  = pmask;
    wr_off_nx = wr_off;
    ppage_nx  = ppage;

    if (byte_stb) begin
      if (byte_idx == '0) begin
        op_nx     = byte_val;
        rd_ptr_nx = '0;
        pmask_nx  = '0;
      end else if (byte_idx <= B3) begin
        addr_nx = addr_full;
        if (byte_idx == B1) wr_hi_nx = byte_val[7:2];
        if (byte_idx == B3 && has_addr) begin
          rd_ptr_nx = addr_full;
          wr_off_nx = addr_full[PW-1:0];
          ppage_nx  = addr_full[AW-1:PW];
        end
      end else if (byte_idx >= B4 && op == OP_PROG) begin
        pbuf_nx[wr_off]  = byte_val;
        pmask_nx[wr_off] = 1'b1;
        wr_off_nx        = wr_off + 1'b1;
      end
    end

    if (fall && in_data) begin
      if (load) begin
        out_sr_nx = src_byte;
        drive_nx  = 1'b1;
        if (osrc != SRC_STAT) rd_ptr_nx = rd_ptr + 1'b1;
      end else if (omode == OUT_DUAL) begin
        out_sr_nx = {out_sr[5:0], 2'b00};
      end else begin
        out_sr_nx = {out_sr[6:0], 1'b0};
      end
    end
    if (cs_n) drive_nx = 1'b0;

    if (done)        wel_nx = 1'b0;
    else if (wren_x) wel_nx = 1'b1;
    else if (wrdi_x) wel_nx = 1'b0;
    if (wrsr_x)  sr_hi_nx = wr_hi;
    if (sleep_x) dpd_nx = 1'b1;
    if (wake_x)  dpd_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= '0; addr <= '0; rd_ptr <= '0; wr_hi <= '0; sr_hi <= '0;
      wel <= 1'b0; dpd <= 1'b0; drive <= 1'b0; out_sr <= '0;
      pbuf <= '0; pmask <= '0; wr_off <= '0; ppage <= '0;
    end else begin
      op <= op_nx; addr <= addr_nx; rd_ptr <= rd_ptr_nx; wr_hi <= wr_hi_nx;
      sr_hi <= sr_hi_nx; wel <= wel_nx; dpd <= dpd_nx; drive <= drive_nx;
      out_sr <= out_sr_nx; pbuf <= pbuf_nx; pmask <= pmask_nx;
      wr_off <= wr_off_nx; ppage <= ppage_nx;
    end
  end

  flash_fe_busy #(.BUSY_CYCLES(BUSY_CYCLES)) i_busy (
    .clk(clk), .rst_n(rst_n), .start(start), .wip(wip), .done(done));

  flash_fe_array #(.AW(AW), .PW(PW), .EW(EW)) i_array (
    .clk(clk), .rst_n(rst_n), .prog(prog_x), .prog_page(ppage),
    .prog_data(pbuf), .prog_mask(pmask), .erase_blk(blk_x),
    .erase_base(addr[AW-1:EW]), .erase_all(all_x), .rd_addr(rd_ptr),
    .rd_data(rd_data));

  assign dq1_o  = out_sr[7];
  assign dq0_o  = out_sr[6];
  assign dq1_oe = ~cs_n & hold_n & drive;
  assign dq0_oe = dq1_oe & (omode == OUT_DUAL);

  // R4: the latch is set only just after a deselect
  assert_wel_after_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_n));
  // R5: a busy cycle begins only with the latch set
  assert_busy_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));
  // R7: the end of a busy cycle leaves the latch clear
  assert_wel_clear_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
  // R11: nothing is driven while asleep
  assert_sleep_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dpd |-> !dq1_oe);
  // R1: a driven DQ1 changes only following a falling serial edge
  assert_out_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dq1_oe && $past(dq1_oe) && !$past(fall)) |-> $stable(dq1_o));
endmodule

// File: tb/test_flash_cmd_front.sv
module test_flash_cmd_front;
  localparam int HALF = 4;
  localparam int BUSY = 400;

  logic clk, rst_n, cs_n, sclk, hold_n, dq0_i;
  logic dq0_o, dq0_oe, dq1_o, dq1_oe;

  flash_cmd_front #(.BUSY_CYCLES(BUSY)) i_flash_cmd_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .hold_n(hold_n),
    .dq0_i(dq0_i), .dq0_o(dq0_o), .dq0_oe(dq0_oe), .dq1_o(dq1_o), .dq1_oe(dq1_oe));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];
  logic [7:0] model [64];
  bit         saw_oe;
  logic [7:0] st_hi = 8'h00;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_b(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      logic [7:0] g, e;
      string t;
      wait (got_q.size() > 0);
      g = got_q.pop_front();
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected byte: actual=%0h expected=none", g);
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (g !== e) begin
          n_bad++;
          $display("FAIL %s: actual=%0h expected=%0h", t, g, e);
        end
      end
    end
  end

  task automatic cs_low; saw_oe = 0; cs_n = 1'b0; tick(HALF); endtask
  task automatic cs_high; tick(HALF); cs_n = 1'b1; tick(2*HALF); endtask
  task automatic send_bit(input bit b);
    dq0_i = b; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask
  task automatic recv_byte(input bit dual, input bit score);
    logic [7:0] v = 8'h00;
    for (int c = 0; c < (dual ? 4 : 8); c++) begin
      tick(HALF);
      if (dq1_oe) saw_oe = 1;
      v = dual ? {v[5:0], dq1_o, dq0_o} : {v[6:0], dq1_o};
      sclk = 1'b1; tick(HALF); sclk = 1'b0;
    end
    if (score) got_q.push_back(v);
  endtask
  task automatic op_only(input logic [7:0] op);
    cs_low; send_byte(op); cs_high;
  endtask
  task automatic send_addr(input logic [23:0] a);
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
  endtask
  task automatic status_chk(input logic [7:0] e, input string tag);
    expect_b(e, tag); cs_low; send_byte(8'h05); recv_byte(0, 1); cs_high;
  endtask
  task automatic read_chk(input logic [7:0] op, input int a, input int n, input string tag);
    for (int i = 0; i < n; i++) expect_b(model[(a + i) % 64], tag);
    cs_low; send_byte(op); send_addr(24'(a));
    if (op != 8'h03) send_byte(8'h00);
    for (int i = 0; i < n; i++) recv_byte(op == 8'h3B, 1);
    cs_high;
  endtask
  task automatic prog(input int a, input logic [7:0] d0, input logic [7:0] d1,
                      input logic [7:0] d2, input int n);
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    cs_low; send_byte(8'h02); send_addr(24'(a));
    for (int i = 0; i < n; i++) send_byte(d[i]);
    cs_high;
  endtask
  task automatic model_prog(input int a, input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input int n);
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    for (int i = 0; i < n; i++) begin
      int idx = (a & ~7) | ((a + i) & 7);
      model[idx] = model[idx] & d[i];
    end
  endtask
  task automatic wait_idle; tick(BUSY + 20); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; hold_n = 1'b1; dq0_i = 1'b0;
    tick(5); rst_n = 1'b1; tick(3);

    // R1 reset state: outputs released
    chk(dq1_oe, 0, "R1 reset dq1_oe");
    chk(dq0_oe, 0, "R1 reset dq0_oe");
    status_chk(8'h00, "R3 status after reset");

    // R2 identification
    expect_b(8'h20, "R2 id byte0"); expect_b(8'h71, "R2 id byte1"); expect_b(8'h17, "R2 id byte2");
    cs_low; send_byte(8'h9F); recv_byte(0,1); recv_byte(0,1); recv_byte(0,1); cs_high;

    // R4 latch set and clear
    op_only(8'h06); status_chk(8'h02, "R4 wel set");
    op_only(8'h04); status_chk(8'h00, "R4 wel cleared");

    // R6 enable with 9 clocks is discarded
    cs_low; send_byte(8'h06); send_bit(0); cs_high;
    status_chk(8'h00, "R6 misaligned enable");

    // R5 modifying commands without the latch
    prog(16, 8'h00, 8'h00, 8'h00, 1);
    status_chk(8'h00, "R5 program without wel");
    read_chk(8'h03, 16, 1, "R5 array untouched");
    cs_low; send_byte(8'h01); send_byte(8'hFC); cs_high;
    status_chk(8'h00, "R5 status write without wel");

    // R7 status write, busy window
    op_only(8'h06);
    cs_low; send_byte(8'h01); send_byte(8'hA8); cs_high;
    st_hi = 8'hA8;
    status_chk(8'hAB, "R7 status while busy R3");
    op_only(8'h06);
    wait_idle;
    status_chk(st_hi, "R7 busy end clears wel, enable ignored");

    // R10 page program
    op_only(8'h06); prog(5, 8'hAA, 8'h55, 8'h00, 2); model_prog(5, 8'hAA, 8'h55, 8'h00, 2);
    wait_idle;
    read_chk(8'h03, 4, 4, "R10 program R1");
    op_only(8'h06); prog(6, 8'h11, 8'h22, 8'h33, 3); model_prog(6, 8'h11, 8'h22, 8'h33, 3);
    wait_idle;
    read_chk(8'h03, 0, 8, "R10 page wrap AND");

    // R8 array wrap and fast read, R9 dual read
    read_chk(8'h03, 63, 2, "R8 array wrap");
    read_chk(8'h0B, 5, 2, "R8 fast read dummy");
    read_chk(8'h3B, 5, 3, "R9 dual read");
    cs_low; send_byte(8'h3B); send_addr(24'd5); send_byte(8'h00); recv_byte(1, 0);
    chk(dq0_oe, 1, "R9 dq0 driven"); cs_high;

    // R12 hold in address and data phases
    expect_b(model[6], "R12 hold in address"); expect_b(model[7], "R12 hold in data");
    cs_low; send_byte(8'h03); send_byte(8'h00);
    hold_n = 1'b0; tick(2);
    for (int i = 0; i < 8; i++) send_bit(1);
    hold_n = 1'b1; tick(2);
    send_byte(8'h00); send_byte(8'h06); recv_byte(0, 1);
    hold_n = 1'b0; tick(2);
    chk(dq1_oe, 0, "R12 output released in hold");
    for (int i = 0; i < 4; i++) send_bit(0);
    hold_n = 1'b1; tick(2);
    recv_byte(0, 1); cs_high;

    // R6 program with stray clocks is discarded
    op_only(8'h06);
    cs_low; send_byte(8'h02); send_addr(24'd32); send_byte(8'h00);
    for (int i = 0; i < 3; i++) send_bit(0);
    cs_high;
    status_chk(st_hi | 8'h02, "R6 discarded keeps wel, no busy");
    read_chk(8'h03, 32, 1, "R6 array untouched");
    op_only(8'h04);

    // R10 block and full erase
    op_only(8'h06); prog(24, 8'h0F, 8'h00, 8'h00, 1); model_prog(24, 8'h0F, 8'h00, 8'h00, 1);
    wait_idle;
    op_only(8'h06); cs_low; send_byte(8'h20); send_addr(24'd3); cs_high;
    for (int i = 0; i < 16; i++) model[i] = 8'hFF;
    wait_idle;
    read_chk(8'h03, 0, 2, "R10 block erase");
    read_chk(8'h03, 24, 1, "R10 block erase bounds");
    op_only(8'h06); op_only(8'hC7);
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
    wait_idle;
    read_chk(8'h03, 24, 1, "R10 full erase");

    // R11 deep power-down
    op_only(8'hB9);
    cs_low; send_byte(8'h9F); recv_byte(0, 0); cs_high;
    chk(saw_oe, 0, "R11 silent while asleep");
    op_only(8'h06);
    op_only(8'hAB);
    status_chk(st_hi, "R11 enable ignored while asleep");
    expect_b(8'h20, "R11 id after release");
    cs_low; send_byte(8'h9F); recv_byte(0, 1); cs_high;

    tick(20);
    wait (got_q.size() == 0);
    tick(2);
    chk(exp_q.size(), 0, "scoreboard drained (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule